// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

The block moves bytes between peripherals and memory while the processor stays off the bus. Four request channels each hold a 16-bit memory address and a 16-bit count word. The processor programs them, along with a mode byte, and reads back a status byte, all through an 8-bit register port with a 4-bit register select. Requests from enabled channels are arbitrated in fixed or rotating order. The winner gets one bus cycle per byte, and each cycle carries its address, an acknowledge strobe, read/write strobes and a last-byte flag.

A cycle starts only after the processor grants the bus through a hold handshake. The bus is modelled with separate input, output and enable signals. External tri-state drivers and address latches are left to the surrounding logic.

Top module: `dma4_ctrl`

## Requirements
- R1: Register select values 0..7 address the channel registers: channel = sel[2:1], sel[0]=0 is the address and sel[0]=1 is the count. Each register is accessed as two byte transfers, low byte first. A shared byte pointer toggles on every channel-register access and returns to the low byte whenever the mode byte is written (sel=8).
- R2: While any enabled channel has its request high, `hrq_o` is asserted. No acknowledge goes low and `addr_oe_o` stays low until `hlda_i` is seen high. At most one `dack_no` bit is low, and only during that channel's transfer cycle.
- R3: A count low field (bits 13:0) of N gives N+1 transfer cycles. Each cycle presents the channel address on `addr_o` and then adds one to it. `tc_o` is high during the cycle in which the field is zero. After that cycle the field stays at zero.
- R4: Count bits 15:14 select the direction. 01 moves peripheral to memory, with `io_rd_o` and `mem_wr_o` high in the data phase. 10 moves memory to peripheral, with `mem_rd_o` and `io_wr_o` high in the data phase. 00 raises no strobe.
- R5: With mode bit 4 clear, the lowest-numbered requesting channel wins every arbitration.
- R6: With mode bit 4 set, the channel just served becomes lowest priority, and the search restarts at the next channel number, wrapping after 3.
- R7: Status bits 3:0 hold one terminal-count flag per channel. A flag sets when that channel finishes its terminal cycle. Reading the status (sel=8) returns the flags and clears them.
- R8: Mode bits 3:0 enable the channels. A channel that finishes its terminal cycle has its enable cleared, unless auto-load (mode bit 7) is set.
- R9: With auto-load set, a terminal cycle reloads that channel's address and count from the values last written by the processor, and it sets the update flag (status bit 4). A status read leaves the flag unchanged. The flag clears when the reloaded channel completes its next cycle, or when the mode byte is written with bit 7 set.
- R10: While `ready_i` is low in the data phase, the cycle is held. The strobes, acknowledge and address stay unchanged.
- R11: An asynchronous low on `rst_ni` clears the mode byte, the status and the sequencer. All bus outputs go inactive at once.
- R12: `hrq_o` drops within two clocks once no enabled channel requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register port select |
| wr_i | input | 1 | Register write strobe, one clock per byte |
| rd_i | input | 1 | Register read strobe, one clock per byte |
| reg_sel_i | input | 4 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while cs_i and rd_i are high |
| dreq_i | input | 4 | Channel requests |
| hlda_i | input | 1 | Bus grant from processor |
| ready_i | input | 1 | Low inserts wait states |
| hrq_o | output | 1 | Bus request to processor |
| dack_no | output | 4 | Per-channel acknowledge, active low |
| addr_o | output | 16 | Memory address of the current cycle |
| addr_oe_o | output | 1 | Address drive enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | Peripheral read strobe |
| io_wr_o | output | 1 | Peripheral write strobe |
| tc_o | output | 1 | Terminal-count cycle flag |

## Verification
The bench uses the default build: four channels, 8-bit data and a 14-bit count field. Counts of 0, 1 and 2 reach the terminal cycle within a few clocks, so the disable, reload and update-flag paths are all exercised. Four channels let the rotating search wrap past channel 3 back to channel 1, and let two channels contend under both fixed and rotating order.

// File: rtl/dma4_pkg.sv
`timescale 1ns/1ps
package dma4_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_ADDR = 2'd2,
    ST_XFER = 2'd3
  } dma_state_e;

  localparam int MODE_ROT_BIT  = 4;
  localparam int MODE_AUTO_BIT = 7;
  localparam logic [1:0] DIR_TO_MEM   = 2'b01;
  localparam logic [1:0] DIR_FROM_MEM = 2'b10;
endpackage

// File: rtl/dma4_regs.sv
`timescale 1ns/1ps
module dma4_regs #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 14,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [CH_W-1:0]               wr_ch_i,
  input  logic                          wr_cnt_i,
  input  logic                          wr_hi_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          step_i,
  input  logic [CH_W-1:0]               step_ch_i,
  input  logic                          reload_i,
  output logic [NUM_CH-1:0][ADDR_W-1:0] addr_o,
  output logic [NUM_CH-1:0][ADDR_W-1:0] cnt_o
);

  function automatic logic [ADDR_W-1:0] put_byte(input logic [ADDR_W-1:0] v,
                                                 input logic hi,
                                                 input logic [DATA_W-1:0] b);
    logic [ADDR_W-1:0] r;
    r = v;
    if (hi) r[ADDR_W-1:DATA_W] = b;
    else    r[DATA_W-1:0]      = b;
    return r;
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ADDR_W-1:0] addr_q, cnt_q, sh_addr_q, sh_cnt_q;
    logic hit_wr, hit_step, at_end;

    assign hit_wr   = wr_en_i && (wr_ch_i == CH_W'(c));
    assign hit_step = step_i && (step_ch_i == CH_W'(c));
    assign at_end   = (cnt_q[CNT_W-1:0] == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_addr_q <= '0;
        sh_cnt_q  <= '0;
      end else if (hit_wr) begin
        if (wr_cnt_i) sh_cnt_q  <= put_byte(sh_cnt_q, wr_hi_i, wr_data_i);
        else          sh_addr_q <= put_byte(sh_addr_q, wr_hi_i, wr_data_i);
      end
    end

    // processor write takes precedence over a same-cycle transfer step
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q <= '0;
        cnt_q  <= '0;
      end else if (hit_wr) begin
        if (wr_cnt_i) cnt_q  <= put_byte(cnt_q, wr_hi_i, wr_data_i);
        else          addr_q <= put_byte(addr_q, wr_hi_i, wr_data_i);
      end else if (hit_step) begin
        if (at_end) begin
          if (reload_i) begin
            addr_q <= sh_addr_q;
            cnt_q  <= sh_cnt_q;
          end else begin
            addr_q <= addr_q + ADDR_W'(1);
          end
        end else begin
          addr_q <= addr_q + ADDR_W'(1);
          cnt_q  <= cnt_q - ADDR_W'(1);
        end
      end
    end

    assign addr_o[c] = addr_q;
    assign cnt_o[c]  = cnt_q;
  end

endmodule

// File: rtl/dma4_arb.sv
`timescale 1ns/1ps
module dma4_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              rotate_i,
  input  logic              adv_i,
  input  logic [CH_W-1:0]   adv_ch_i,
  output logic [CH_W-1:0]   gnt_ch_o,
  output logic              gnt_vld_o
);

  logic [CH_W-1:0] top_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                top_q <= '0;
    else if (adv_i && rotate_i) top_q <= adv_ch_i + CH_W'(1);
  end

  always_comb begin : p_pick
    logic [CH_W-1:0] base;
    logic [CH_W-1:0] idx;
    base      = rotate_i ? top_q : '0;
    gnt_vld_o = 1'b0;
    gnt_ch_o  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      idx = base + CH_W'(i);
      if (!gnt_vld_o && req_i[idx]) begin
        gnt_vld_o = 1'b1;
        gnt_ch_o  = idx;
      end
    end
  end

endmodule

// File: rtl/dma4_seq.sv
`timescale 1ns/1ps
module dma4_seq
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_any_i,
  input  logic            hlda_i,
  input  logic            ready_i,
  input  logic [CH_W-1:0] gnt_ch_i,
  output logic [CH_W-1:0] act_ch_o,
  output logic            hrq_o,
  output logic            in_cycle_o,
  output logic            strobe_o,
  output logic            done_o
);

  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_any_i) state_d = ST_HOLD;
      ST_HOLD: begin
        if (!req_any_i)  state_d = ST_IDLE;
        else if (hlda_i) state_d = ST_ADDR;
      end
      ST_ADDR: state_d = ST_XFER;
      ST_XFER: if (ready_i) state_d = ST_HOLD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      act_ch_o <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_HOLD && state_d == ST_ADDR) act_ch_o <= gnt_ch_i;
    end
  end

  assign hrq_o      = (state_q != ST_IDLE);
  assign in_cycle_o = (state_q == ST_ADDR) || (state_q == ST_XFER);
  assign strobe_o   = (state_q == ST_XFER);
  assign done_o     = (state_q == ST_XFER) && ready_i;

  a_r2_cycle_needs_hlda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_cycle_o) |-> $past(hlda_i));

  a_r10_wait_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !ready_i) |=> (strobe_o && $stable(act_ch_o)));

endmodule

// File: rtl/dma4_ctrl.sv
`timescale 1ns/1ps
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 14,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = 2 * DATA_W,
  localparam int SEL_W  = CH_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] dreq_i,
  input  logic              hlda_i,
  input  logic              ready_i,
  output logic              hrq_o,
  output logic [NUM_CH-1:0] dack_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              io_rd_o,
  output logic              io_wr_o,
  output logic              tc_o
);

  logic cpu_wr, cpu_rd, sel_mode, sel_ch, sel_cnt;
  logic [CH_W-1:0] sel_idx;
  logic ptr_q;
  logic [DATA_W-1:0] mode_q;
  logic [NUM_CH-1:0] tc_q, tc_set, req;
  logic upd_q;
  logic [CH_W-1:0] upd_ch_q;
  logic [NUM_CH-1:0][ADDR_W-1:0] addr_arr, cnt_arr;
  logic [CH_W-1:0] gnt_ch, act_ch;
  logic gnt_vld, in_cycle, strobe, done, tc_hit, auto_ld;
  logic [ADDR_W-1:0] rd_val;
  logic [1:0] dir;

  assign cpu_wr   = cs_i && wr_i;
  assign cpu_rd   = cs_i && rd_i;
  assign sel_mode = (reg_sel_i == SEL_W'(2 * NUM_CH));
  assign sel_ch   = (reg_sel_i < SEL_W'(2 * NUM_CH));
  assign sel_idx  = reg_sel_i[CH_W:1];
  assign sel_cnt  = reg_sel_i[0];
  assign auto_ld  = mode_q[MODE_AUTO_BIT];
  assign req      = dreq_i & mode_q[NUM_CH-1:0];

  // byte pointer: shared by all channel registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ptr_q <= 1'b0;
    else if (cpu_wr && sel_mode)                ptr_q <= 1'b0;
    else if ((cpu_wr || cpu_rd) && sel_ch)      ptr_q <= ~ptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                mode_q <= '0;
    else if (cpu_wr && sel_mode)                mode_q <= wdata_i;
    else if (done && tc_hit && !auto_ld)        mode_q[act_ch] <= 1'b0;
  end

  assign tc_set = (done && tc_hit) ? (NUM_CH'(1) << act_ch) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tc_q <= '0;
    else         tc_q <= ((cpu_rd && sel_mode) ? '0 : tc_q) | tc_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q    <= 1'b0;
      upd_ch_q <= '0;
    end else if (done && tc_hit && auto_ld) begin
      upd_q    <= 1'b1;
      upd_ch_q <= act_ch;
    end else if (cpu_wr && sel_mode && wdata_i[MODE_AUTO_BIT]) begin
      upd_q <= 1'b0;
    end else if (done && act_ch == upd_ch_q) begin
      upd_q <= 1'b0;
    end
  end

  dma4_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cpu_wr && sel_ch),
    .wr_ch_i   (sel_idx),
    .wr_cnt_i  (sel_cnt),
    .wr_hi_i   (ptr_q),
    .wr_data_i (wdata_i),
    .step_i    (done),
    .step_ch_i (act_ch),
    .reload_i  (auto_ld),
    .addr_o    (addr_arr),
    .cnt_o     (cnt_arr)
  );

  dma4_arb #(.NUM_CH(NUM_CH)) i_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .rotate_i  (mode_q[MODE_ROT_BIT]),
    .adv_i     (done),
    .adv_ch_i  (act_ch),
    .gnt_ch_o  (gnt_ch),
    .gnt_vld_o (gnt_vld)
  );

  dma4_seq #(.NUM_CH(NUM_CH)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_any_i  (gnt_vld),
    .hlda_i     (hlda_i),
    .ready_i    (ready_i),
    .gnt_ch_i   (gnt_ch),
    .act_ch_o   (act_ch),
    .hrq_o      (hrq_o),
    .in_cycle_o (in_cycle),
    .strobe_o   (strobe),
    .done_o     (done)
  );

  assign tc_hit = (cnt_arr[act_ch][CNT_W-1:0] == '0);
  assign dir    = cnt_arr[act_ch][ADDR_W-1:ADDR_W-2];

  always_comb begin
    rd_val  = sel_cnt ? cnt_arr[sel_idx] : addr_arr[sel_idx];
    rdata_o = '0;
    if (cpu_rd) begin
      if (sel_mode)    rdata_o = DATA_W'({upd_q, tc_q});
      else if (sel_ch) rdata_o = ptr_q ? rd_val[ADDR_W-1:DATA_W] : rd_val[DATA_W-1:0];
    end
  end

  assign dack_no   = in_cycle ? ~(NUM_CH'(1) << act_ch) : '1;
  assign addr_oe_o = in_cycle;
  assign addr_o    = in_cycle ? addr_arr[act_ch] : '0;
  assign mem_wr_o  = strobe && (dir == DIR_TO_MEM);
  assign io_rd_o   = strobe && (dir == DIR_TO_MEM);
  assign mem_rd_o  = strobe && (dir == DIR_FROM_MEM);
  assign io_wr_o   = strobe && (dir == DIR_FROM_MEM);
  assign tc_o      = in_cycle && tc_hit;

  a_r2_dack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dack_no));

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !tc_hit && !(cpu_wr && sel_ch))
      |=> addr_arr[$past(act_ch)] == ($past(addr_arr[act_ch]) + ADDR_W'(1)));

  a_r7_tc_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && tc_hit) |=> tc_q[$past(act_ch)]);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hrq_o |-> (&dack_no && !addr_oe_o && !mem_rd_o && !mem_wr_o));

endmodule

// File: tb/test_dma4_ctrl.sv
`timescale 1ns/1ps
module test_dma4_ctrl;

  typedef struct packed {
    logic [1:0]  ch;
    logic [15:0] addr;
    logic [1:0]  dir;
    logic        tc;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, wr = 0, rd = 0;
  logic [3:0] sel = '0;
  logic [7:0] wdata = '0, rdata;
  logic [3:0] dreq = '0;
  logic hlda = 0, ready = 1;
  logic hrq, addr_oe, mem_rd, mem_wr, io_rd, io_wr, tc;
  logic [3:0] dack_n;
  logic [15:0] addr;

  int n_chk = 0, n_err = 0;
  item_t exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  dma4_ctrl i_dma4_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .rd_i(rd),
    .reg_sel_i(sel), .wdata_i(wdata), .rdata_o(rdata), .dreq_i(dreq),
    .hlda_i(hlda), .ready_i(ready), .hrq_o(hrq), .dack_no(dack_n),
    .addr_o(addr), .addr_oe_o(addr_oe), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .io_rd_o(io_rd), .io_wr_o(io_wr), .tc_o(tc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  task automatic cpu_write(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; sel = s; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic cpu_read(input logic [3:0] s, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; sel = s;
    #1 d = rdata;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic prog_ch(input int ch, input logic [15:0] a, input logic [15:0] c);
    cpu_write(4'(2 * ch), a[7:0]);
    cpu_write(4'(2 * ch), a[15:8]);
    cpu_write(4'(2 * ch + 1), c[7:0]);
    cpu_write(4'(2 * ch + 1), c[15:8]);
  endtask

  task automatic expect_xfer(input int ch, input logic [15:0] a, input logic [1:0] d,
                             input logic t, input string tag);
    item_t it;
    it.ch = 2'(ch); it.addr = a; it.dir = d; it.tc = t;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  task automatic drive_ch(input int ch, input int n);
    int seen = 0;
    @(negedge clk);
    dreq[ch] = 1'b1;
    for (int k = 0; k < 2000 && seen < n; k++) begin
      @(negedge clk); #1;
      if (!dack_n[ch] && (mem_rd || mem_wr) && ready) begin
        seen++;
        if (seen == n) dreq[ch] = 1'b0;
      end
    end
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic status_is(input logic [7:0] e, input string tag);
    logic [7:0] v;
    cpu_read(4'd8, v);
    chk(tag, v, e);
  endtask

  // scoreboard monitor: one item per completed data phase
  always begin
    @(negedge clk); #1;
    if (rst_n && (mem_rd || mem_wr) && ready) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected transfer", {dack_n, addr}, 32'hFFFF_FFFF);
      end else begin
        item_t e;
        string t;
        logic [1:0] ch_obs, dir_obs;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        ch_obs = !dack_n[0] ? 2'd0 : !dack_n[1] ? 2'd1 : !dack_n[2] ? 2'd2 : 2'd3;
        dir_obs = (mem_wr && io_rd) ? 2'b01 : (mem_rd && io_wr) ? 2'b10 : 2'b11;
        chk({t, " channel"}, ch_obs, e.ch);
        chk("R3 address", addr, e.addr);
        chk("R3 terminal flag", tc, e.tc);
        chk("R4 direction strobes", dir_obs, e.dir);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R11 reset state
    chk("R11 hrq after reset", hrq, 0);
    chk("R11 dack after reset", dack_n, 4'hF);
    chk("R11 addr_oe after reset", addr_oe, 0);
    chk("R11 strobes after reset", {mem_rd, mem_wr, io_rd, io_wr, tc}, 0);
    status_is(8'h00, "R11 status after reset");

    // R1 byte pointer and its reset on mode write
    cpu_write(4'd8, 8'h00);
    cpu_write(4'd2, 8'h11);
    cpu_write(4'd8, 8'h00);
    cpu_write(4'd2, 8'h22);
    cpu_write(4'd2, 8'h33);
    cpu_read(4'd2, v); chk("R1 addr low byte", v, 8'h22);
    cpu_read(4'd2, v); chk("R1 addr high byte", v, 8'h33);

    // R2/R12 bus handshake
    prog_ch(0, 16'h1234, 16'h4002);
    cpu_write(4'd8, 8'h01);
    @(negedge clk); dreq[0] = 1;
    repeat (4) @(negedge clk); #1;
    chk("R2 hrq while waiting", hrq, 1);
    chk("R2 no dack before grant", dack_n, 4'hF);
    chk("R2 no addr drive before grant", addr_oe, 0);
    dreq[0] = 0;
    repeat (3) @(negedge clk); #1;
    chk("R12 hrq dropped", hrq, 0);

    // R3/R4/R8 three-cycle transfer on channel 0
    expect_xfer(0, 16'h1234, 2'b01, 0, "R3");
    expect_xfer(0, 16'h1235, 2'b01, 0, "R3");
    expect_xfer(0, 16'h1236, 2'b01, 1, "R3");
    hlda = 1;
    @(negedge clk); dreq[0] = 1;
    wait_drain();
    repeat (4) @(negedge clk); #1;
    chk("R8 channel disabled after terminal count", hrq, 0);
    dreq[0] = 0;
    status_is(8'h01, "R7 terminal flag set");
    status_is(8'h00, "R7 cleared by read");
    cpu_write(4'd8, 8'h00);
    cpu_read(4'd0, v); chk("R3 final address low", v, 8'h37);
    cpu_read(4'd0, v); chk("R3 final address high", v, 8'h12);
    cpu_read(4'd1, v); chk("R3 count low stays zero", v, 8'h00);
    cpu_read(4'd1, v); chk("R3 count high keeps direction", v, 8'h40);

    // R5 fixed priority
    prog_ch(1, 16'h0100, 16'h8001);
    prog_ch(2, 16'h0200, 16'h8001);
    expect_xfer(1, 16'h0100, 2'b10, 0, "R5");
    expect_xfer(1, 16'h0101, 2'b10, 1, "R5");
    expect_xfer(2, 16'h0200, 2'b10, 0, "R5");
    expect_xfer(2, 16'h0201, 2'b10, 1, "R5");
    cpu_write(4'd8, 8'h06);
    @(negedge clk); dreq = 4'b0110;
    wait_drain();
    dreq = 0;
    status_is(8'h06, "R7 two channel flags");

    // R6 rotating priority
    cpu_write(4'd8, 8'h00);
    prog_ch(1, 16'h0300, 16'h8001);
    prog_ch(2, 16'h0400, 16'h8001);
    expect_xfer(1, 16'h0300, 2'b10, 0, "R6");
    expect_xfer(2, 16'h0400, 2'b10, 0, "R6");
    expect_xfer(1, 16'h0301, 2'b10, 1, "R6");
    expect_xfer(2, 16'h0401, 2'b10, 1, "R6");
    cpu_write(4'd8, 8'h16);
    @(negedge clk); dreq = 4'b0110;
    wait_drain();
    dreq = 0;
    status_is(8'h06, "R7 flags after rotation");

    // R10 wait states
    cpu_write(4'd8, 8'h00);
    prog_ch(3, 16'h0F00, 16'h4000);
    ready = 0;
    cpu_write(4'd8, 8'h08);
    expect_xfer(3, 16'h0F00, 2'b01, 1, "R10");
    @(negedge clk); dreq[3] = 1;
    for (int k = 0; k < 100 && !mem_wr; k++) begin @(negedge clk); #1; end
    for (int k = 0; k < 3; k++) begin
      chk("R10 strobe held", {mem_wr, io_rd, dack_n}, {2'b11, 4'b0111});
      chk("R10 address held", addr, 16'h0F00);
      @(negedge clk); #1;
    end
    @(negedge clk);
    ready = 1; dreq[3] = 0;
    wait_drain();
    status_is(8'h08, "R7 channel 3 flag");

    // R9 auto-load and update flag
    cpu_write(4'd8, 8'h00);
    prog_ch(0, 16'h2000, 16'h4001);
    cpu_write(4'd8, 8'h81);
    expect_xfer(0, 16'h2000, 2'b01, 0, "R9");
    expect_xfer(0, 16'h2001, 2'b01, 1, "R9");
    drive_ch(0, 2);
    wait_drain();
    status_is(8'h11, "R9 update flag and terminal flag");
    status_is(8'h10, "R9 status read keeps update flag");
    expect_xfer(0, 16'h2000, 2'b01, 0, "R8 reloaded channel still enabled");
    drive_ch(0, 1);
    wait_drain();
    status_is(8'h00, "R9 update cycle clears flag");
    expect_xfer(0, 16'h2001, 2'b01, 1, "R9");
    drive_ch(0, 1);
    wait_drain();
    status_is(8'h11, "R9 flag set again");
    cpu_write(4'd8, 8'h81);
    status_is(8'h00, "R9 auto-load mode write clears flag");
    cpu_read(4'd0, v); chk("R9 reloaded address low", v, 8'h00);
    cpu_read(4'd0, v); chk("R9 reloaded address high", v, 8'h20);

    // R11 asynchronous reset mid-cycle
    cpu_write(4'd8, 8'h00);
    prog_ch(1, 16'h5555, 16'h4010);
    ready = 0;
    cpu_write(4'd8, 8'h02);
    @(negedge clk); dreq[1] = 1;
    for (int k = 0; k < 100 && dack_n[1]; k++) begin @(negedge clk); #1; end
    chk("R2 channel 1 acknowledged", dack_n, 4'b1101);
    rst_n = 0;
    #1;
    chk("R11 async hrq", hrq, 0);
    chk("R11 async dack", dack_n, 4'hF);
    chk("R11 async addr drive", {addr_oe, mem_rd, mem_wr}, 0);
    @(negedge clk);
    rst_n = 1; ready = 1;
    repeat (4) @(negedge clk); #1;
    chk("R11 mode cleared keeps bus idle", hrq, 0);
    dreq[1] = 0;
    status_is(8'h00, "R11 status cleared");

    chk("R3 scoreboard drained", exp_q.size(), 0);
    report();
  end

endmodule